// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block sequences a processor core through four power states: running, halted with the bus alive, sleeping, and deep sleeping. Three asynchronous request lines (stop-clock, sleep and deep-sleep) drive it. It turns them into clock-enable levels for the core clock domains and for the bus and interrupt-controller domain. It also produces a one-cycle request for the bus unit to issue a halt acknowledge transaction, and a power-status flag that marks the deepest state.

A single output line is shared between two meanings. While stop-clock is released, it mirrors the floating-point error flag. While stop-clock is held, it reports a pending wake-up event. That event is raised by a break source or a debug probe request, and it stays latched until stop-clock is released. Each sleep request acts only in the state directly above the one it selects. In any other state the request is ignored.

Every asynchronous input passes through a two-flop synchroniser. The state machine sits in a control module. Registered enables, the acknowledge pulse and the event latch sit in a datapath module. The control module passes the datapath a small struct of strobes.

Top module: `coreSleepSeq`

## Requirements
- R1: During and after reset with all inputs low, all core clock enables and the bus clock enable are 1, and the acknowledge, power-status and shared outputs are 0.
- R2: Stop-clock asserted in the running state clears every core clock enable and keeps the bus clock enable at 1. The acknowledge output is high for exactly one cycle, and it is raised only on entry from the running state.
- R3: The sleep input takes effect only in the halted state. In the running state it leaves all enables at 1.
- R4: In the sleep state, all core and bus clock enables are 0. Releasing sleep returns the core to the halted state, where the bus enable is 1 and the core enables are 0. Releasing stop-clock while sleeping has no effect on the enables.
- R5: The deep-sleep input takes effect only in the sleep state. In the running or halted state it changes neither the enables nor the power-status output. Releasing it returns the core to the sleep state.
- R6: The power-status output is 1 exactly while in the deep-sleep state.
- R7: Releasing stop-clock in the halted state returns the core to running, with all clock enables at 1.
- R8: While the synchronised stop-clock is low, the shared output equals the synchronised floating-point error input.
- R9: While the synchronised stop-clock is high, the shared output is the pending-event latch. A break source or a probe request sets the latch. The latch holds after its source drops, and it clears when stop-clock goes low.
- R10: A change on any asynchronous input reaches the state-dependent outputs on the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| stopClkIn | input | 1 | Asynchronous stop-clock request, active high |
| sleepIn | input | 1 | Asynchronous sleep request, active high |
| deepSleepIn | input | 1 | Asynchronous deep-sleep request, active high |
| probeReqIn | input | 1 | Asynchronous debug probe request, active high |
| breakSrcIn | input | 1 | Asynchronous break-event source, active high |
| fpErrIn | input | 1 | Floating-point error flag |
| coreClkEn | output | CORE_DOMAINS | Core clock-domain enables |
| busClkEn | output | 1 | Bus and interrupt-controller clock enable |
| stopGrantAck | output | 1 | One-cycle request for a halt acknowledge transaction |
| pwrStatusInd | output | 1 | High while in deep sleep |
| fpErrBreakOut | output | 1 | Shared error / pending-event output |

## Verification
An input change made just after a falling edge is captured on the next rising edge and is synchronised on the second. State, enables, acknowledge and latch all update on the third edge. The shared output's mux select follows the synchronised stop-clock from the second edge. The bench therefore waits three rising edges after each stimulus and samples 1 ns later. At that point every result due from the stimulus is stable. For the acknowledge pulse, the bench also samples one edge later to confirm the output has dropped.

// File: rtl/coreSleepPkg.sv
package coreSleepPkg;

  typedef enum logic [1:0] {
    PS_NORMAL    = 2'd0,
    PS_STOPGRANT = 2'd1,
    PS_SLEEP     = 2'd2,
    PS_DEEP      = 2'd3
  } pwrState_e;

  // strobes from control to datapath, decoded from the next state
  typedef struct packed {
    logic coreOn;
    logic busOn;
    logic deepOn;
    logic ackPulse;
  } dpStrobe_t;

  localparam int SYNC_W    = 6;
  localparam int IDX_STOP  = 0;
  localparam int IDX_SLEEP = 1;
  localparam int IDX_DEEP  = 2;
  localparam int IDX_PROBE = 3;
  localparam int IDX_BRK   = 4;
  localparam int IDX_FPERR = 5;

endpackage

// File: rtl/coreSleepSync.sv
module coreSleepSync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], asyncIn[b]};
    end
    assign syncOut[b] = chain[LAST];
  end

endmodule

// File: rtl/coreSleepCtrl.sv
module coreSleepCtrl
  import coreSleepPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      stopSync,
  input  logic      sleepSync,
  input  logic      deepSync,
  output dpStrobe_t strobe
);
  pwrState_e state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      PS_NORMAL:    if (stopSync) nextState = PS_STOPGRANT;
      PS_STOPGRANT: begin
        if (!stopSync)      nextState = PS_NORMAL;
        else if (sleepSync) nextState = PS_SLEEP;
      end
      PS_SLEEP: begin
        if (!sleepSync)     nextState = PS_STOPGRANT;
        else if (deepSync)  nextState = PS_DEEP;
      end
      PS_DEEP:      if (!deepSync) nextState = PS_SLEEP;
      default:      nextState = PS_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PS_NORMAL;
    else       state <= nextState;
  end

  always_comb begin
    strobe.coreOn   = (nextState == PS_NORMAL);
    strobe.busOn    = (nextState == PS_NORMAL) || (nextState == PS_STOPGRANT);
    strobe.deepOn   = (nextState == PS_DEEP);
    strobe.ackPulse = (state == PS_NORMAL) && (nextState == PS_STOPGRANT);
  end

  // R3: sleep is only ever entered from the halted state
  assert_sleep_from_halt_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_SLEEP && $past(state) != PS_SLEEP) |-> ($past(state) == PS_STOPGRANT || $past(state) == PS_DEEP));

  // R5: deep sleep is only ever entered from sleep
  assert_deep_from_sleep_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_DEEP && $past(state) != PS_DEEP) |-> $past(state) == PS_SLEEP);

  // R7: return to running requires stop-clock released
  assert_resume_needs_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_NORMAL && $past(state) == PS_STOPGRANT) |-> !$past(stopSync));

endmodule

// File: rtl/coreSleepDatapath.sv
module coreSleepDatapath
  import coreSleepPkg::*;
#(
  parameter int CORE_DOMAINS = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               strobe,
  input  logic                    stopSync,
  input  logic                    probeSync,
  input  logic                    brkSync,
  input  logic                    fpErrSync,
  output logic [CORE_DOMAINS-1:0] coreClkEn,
  output logic                    busClkEn,
  output logic                    stopGrantAck,
  output logic                    pwrStatusInd,
  output logic                    fpErrBreakOut
);
  logic breakPend;

  for (genvar d = 0; d < CORE_DOMAINS; d++) begin : g_core
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) coreClkEn[d] <= 1'b1;
      else       coreClkEn[d] <= strobe.coreOn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busClkEn     <= 1'b1;
      stopGrantAck <= 1'b0;
      pwrStatusInd <= 1'b0;
    end else begin
      busClkEn     <= strobe.busOn;
      stopGrantAck <= strobe.ackPulse;
      pwrStatusInd <= strobe.deepOn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       breakPend <= 1'b0;
    else if (!stopSync)              breakPend <= 1'b0;
    else if (brkSync || probeSync)   breakPend <= 1'b1;
  end

  assign fpErrBreakOut = stopSync ? breakPend : fpErrSync;

  // R2: acknowledge request never lasts more than one cycle
  assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    stopGrantAck |=> !stopGrantAck);

  // R4: core domains are never clocked while the bus domain is stopped
  assert_core_off_without_bus_R4: assert property (@(posedge clk) disable iff (!rstN)
    !busClkEn |-> (coreClkEn == '0));

  // R6: power-status only with all clocks stopped
  assert_psi_clocks_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    pwrStatusInd |-> !busClkEn);

  // R9: pending event holds while stop-clock stays active
  assert_break_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (breakPend && stopSync) |=> breakPend);

endmodule

// File: rtl/coreSleepSeq.sv
module coreSleepSeq
  import coreSleepPkg::*;
#(
  parameter int CORE_DOMAINS = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    stopClkIn,
  input  logic                    sleepIn,
  input  logic                    deepSleepIn,
  input  logic                    probeReqIn,
  input  logic                    breakSrcIn,
  input  logic                    fpErrIn,
  output logic [CORE_DOMAINS-1:0] coreClkEn,
  output logic                    busClkEn,
  output logic                    stopGrantAck,
  output logic                    pwrStatusInd,
  output logic                    fpErrBreakOut
);
  logic [SYNC_W-1:0] rawIn, syncIn;
  dpStrobe_t         strobe;

  always_comb begin
    rawIn            = '0;
    rawIn[IDX_STOP]  = stopClkIn;
    rawIn[IDX_SLEEP] = sleepIn;
    rawIn[IDX_DEEP]  = deepSleepIn;
    rawIn[IDX_PROBE] = probeReqIn;
    rawIn[IDX_BRK]   = breakSrcIn;
    rawIn[IDX_FPERR] = fpErrIn;
  end

  coreSleepSync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(rawIn), .syncOut(syncIn)
  );

  coreSleepCtrl uCtrl (
    .clk(clk), .rstN(rstN),
    .stopSync(syncIn[IDX_STOP]), .sleepSync(syncIn[IDX_SLEEP]),
    .deepSync(syncIn[IDX_DEEP]), .strobe(strobe)
  );

  coreSleepDatapath #(.CORE_DOMAINS(CORE_DOMAINS)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .stopSync(syncIn[IDX_STOP]), .probeSync(syncIn[IDX_PROBE]),
    .brkSync(syncIn[IDX_BRK]), .fpErrSync(syncIn[IDX_FPERR]),
    .coreClkEn(coreClkEn), .busClkEn(busClkEn), .stopGrantAck(stopGrantAck),
    .pwrStatusInd(pwrStatusInd), .fpErrBreakOut(fpErrBreakOut)
  );

endmodule

// File: tb/coreSleepSeq_test.sv
module coreSleepSeq_test;
  localparam int CD = 4;
  localparam logic [CD-1:0] ALL_ON = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopClkIn = 0, sleepIn = 0, deepSleepIn = 0, probeReqIn = 0, breakSrcIn = 0, fpErrIn = 0;
  logic [CD-1:0] coreClkEn;
  logic busClkEn, stopGrantAck, pwrStatusInd, fpErrBreakOut;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  coreSleepSeq #(.CORE_DOMAINS(CD)) uut (
    .clk(clk), .rstN(rstN), .stopClkIn(stopClkIn), .sleepIn(sleepIn),
    .deepSleepIn(deepSleepIn), .probeReqIn(probeReqIn), .breakSrcIn(breakSrcIn),
    .fpErrIn(fpErrIn), .coreClkEn(coreClkEn), .busClkEn(busClkEn),
    .stopGrantAck(stopGrantAck), .pwrStatusInd(pwrStatusInd), .fpErrBreakOut(fpErrBreakOut)
  );

  task automatic check(string req, string what, logic [CD-1:0] act, logic [CD-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // R10: results due on the third rising edge after a change driven after a falling edge
  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic drive_at_negedge();
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R1", "core enables in reset", coreClkEn, ALL_ON);
    check("R1", "bus enable in reset", {3'b0, busClkEn}, 4'd1);
    @(negedge clk); rstN = 1'b1;
    #1;
    check("R1", "ack after reset", {3'b0, stopGrantAck}, 4'd0);
    check("R1", "psi after reset", {3'b0, pwrStatusInd}, 4'd0);
    check("R1", "shared out after reset", {3'b0, fpErrBreakOut}, 4'd0);
  endtask

  task automatic t_fp_mirror();
    drive_at_negedge(); fpErrIn = 1; settle();
    check("R8", "shared follows fp error high", {3'b0, fpErrBreakOut}, 4'd1);
    drive_at_negedge(); fpErrIn = 0; settle();
    check("R8", "shared follows fp error low", {3'b0, fpErrBreakOut}, 4'd0);
  endtask

  task automatic t_sleep_ignored_running();
    drive_at_negedge(); sleepIn = 1; deepSleepIn = 1; settle();
    check("R3", "core stays on with sleep in running", coreClkEn, ALL_ON);
    check("R5", "bus stays on with deep in running", {3'b0, busClkEn}, 4'd1);
    check("R5", "psi stays low in running", {3'b0, pwrStatusInd}, 4'd0);
    drive_at_negedge(); sleepIn = 0; deepSleepIn = 0; settle();
  endtask

  task automatic t_stop_grant();
    drive_at_negedge(); stopClkIn = 1;
    repeat (3) @(posedge clk); #1;
    check("R2", "ack on entry", {3'b0, stopGrantAck}, 4'd1);
    check("R2", "core off in halt", coreClkEn, '0);
    check("R2", "bus on in halt", {3'b0, busClkEn}, 4'd1);
    @(posedge clk); #1;
    check("R2", "ack one cycle only", {3'b0, stopGrantAck}, 4'd0);
    drive_at_negedge(); deepSleepIn = 1; settle();
    check("R5", "deep ignored in halt: bus", {3'b0, busClkEn}, 4'd1);
    check("R5", "deep ignored in halt: psi", {3'b0, pwrStatusInd}, 4'd0);
    drive_at_negedge(); deepSleepIn = 0; settle();
  endtask

  task automatic t_break_latch();
    drive_at_negedge(); fpErrIn = 1; settle();
    check("R9", "fp error hidden while stopped", {3'b0, fpErrBreakOut}, 4'd0);
    drive_at_negedge(); breakSrcIn = 1; settle();
    check("R9", "break source sets event", {3'b0, fpErrBreakOut}, 4'd1);
    drive_at_negedge(); breakSrcIn = 0; settle();
    check("R9", "event held after source drops", {3'b0, fpErrBreakOut}, 4'd1);
  endtask

  task automatic t_sleep_deep();
    drive_at_negedge(); sleepIn = 1; settle();
    check("R4", "bus off in sleep", {3'b0, busClkEn}, 4'd0);
    check("R4", "core off in sleep", coreClkEn, '0);
    drive_at_negedge(); stopClkIn = 0; settle();
    check("R4", "stop release ignored in sleep", {3'b0, busClkEn}, 4'd0);
    check("R8", "shared shows fp error once stop released", {3'b0, fpErrBreakOut}, 4'd1);
    drive_at_negedge(); stopClkIn = 1; settle();
    check("R9", "event cleared by stop release", {3'b0, fpErrBreakOut}, 4'd0);
    drive_at_negedge(); deepSleepIn = 1; settle();
    check("R6", "psi high in deep", {3'b0, pwrStatusInd}, 4'd1);
    check("R4", "bus off in deep", {3'b0, busClkEn}, 4'd0);
    drive_at_negedge(); deepSleepIn = 0; settle();
    check("R6", "psi low back in sleep", {3'b0, pwrStatusInd}, 4'd0);
    check("R5", "bus still off back in sleep", {3'b0, busClkEn}, 4'd0);
    drive_at_negedge(); sleepIn = 0; settle();
    check("R4", "bus on back in halt", {3'b0, busClkEn}, 4'd1);
    check("R4", "core off back in halt", coreClkEn, '0);
    check("R2", "no ack on return from sleep", {3'b0, stopGrantAck}, 4'd0);
  endtask

  task automatic t_probe_resume();
    drive_at_negedge(); probeReqIn = 1; settle();
    check("R9", "probe sets event", {3'b0, fpErrBreakOut}, 4'd1);
    drive_at_negedge(); probeReqIn = 0; stopClkIn = 0; settle();
    check("R7", "core on after resume", coreClkEn, ALL_ON);
    check("R7", "bus on after resume", {3'b0, busClkEn}, 4'd1);
    check("R8", "shared back to fp error", {3'b0, fpErrBreakOut}, 4'd1);
    drive_at_negedge(); fpErrIn = 0; settle();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fp_mirror();
    t_sleep_ignored_running();
    t_stop_grant();
    t_break_latch();
    t_sleep_deep();
    t_probe_resume();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule